// File: doc/BRIEF.md
# Auto-Reload Variable-Width PWM Channel

This block is one compare channel of a pulse-width modulator that follows the low bits of a shared, free-running timebase counter. A selectable cycle length of 9, 10 or 11 bits sets the PWM period. The output goes high when the masked count reaches the channel's compare value. It goes low again when the masked count wraps from all ones to zero.

Software writes the duty value into an auto-reload register. On each wrap the block copies that register into the compare register, so a new duty always starts at a period boundary. The auto-reload register and the compare register share the same two byte addresses on an 8-bit register bus. A select bit in the configuration register decides which of the two a bus access reaches. A low-byte write turns the comparator off and a high-byte write turns it back on, so the low byte is written first. Two sticky flags report compare matches and counter wraps.

The counter value arrives already divided by the shared timebase. The channel acts only in cycles where the masked count differs from the value it held in the previous clock. The register bus is a plain single-cycle write strobe with a combinational read, and it has no back-pressure. The counter input and the pin are plain level signals.

Top module: `arpwm_channel`

## Requirements
- R1: When the channel is active and the masked count changes to a value equal to the effective compare value, `pwm_out` is 1 after that clock edge. The effective compare value is the auto-reload value in a wrap cycle and the compare register otherwise.
- R2: When the channel is active and the masked count wraps from all ones to zero, `pwm_out` is 0 after that edge. If the effective compare value is 0, R1 wins and the output stays high, giving 100% duty.
- R3: On every wrap, `ovf_flag` (configuration bit 7) is set. If the channel is also active, the compare register takes the auto-reload value at the same edge. A bus write to a duty byte in that same cycle overrides the reloaded byte.
- R4: Configuration bits [1:0] select the length: 00 gives 9 bits, 01 gives 10 bits, and 10 or 11 give 11 bits. With the counter advancing every clock, the period is 512, 1024 or 2048 clocks.
- R5: Address 1 holds the low duty byte and address 2 the high byte. When configuration bit 6 is 1, reads and writes of these addresses reach the auto-reload register. When it is 0, they reach the compare register.
- R6: Duty values are right-justified: address 1 carries bits 7:0 and address 2 carries bits 15:8. A 16-bit value of 2^N or more never matches, so the output stays low.
- R7: Mode bit 0 enables the match flag. When it is set, every R1 match sets `match_flag` (mode bit 7). When it is clear, matches leave the flag alone.
- R8: Any write to address 1 clears the comparator enable (mode bit 2), and any write to address 2 sets it, whatever the value of configuration bit 6.
- R9: The channel is active only when mode bit 2 (comparator enable) and mode bit 1 (PWM mode) are both 1. While it is inactive, `pwm_out` is 0 after each edge and no reload takes place. While it is active, the duty is (2^N - compare)/2^N.
- R10: Both flags are sticky. A bus write to the flag's register with a 0 in bit 7 clears the flag, and a 1 leaves it unchanged. A hardware set in the same cycle takes priority over the clear.
- R11: After reset, all four registers read 0, `pwm_out` is 0 and the length is 9 bits.
- R12: While the masked count holds still across clocks, no match or wrap is seen again, so a cleared match flag stays clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Channel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_low_i | input | MAX_N | Low bits of the shared timebase counter |
| wr_en | input | 1 | Register write strobe, one byte per cycle |
| wr_addr | input | 2 | Write address: 0 mode, 1 duty low, 2 duty high, 3 configuration |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address, same map as the write address |
| rd_data | output | 8 | Combinational read data |
| pwm_out | output | 1 | PWM pin |
| match_flag | output | 1 | Sticky compare-match flag |
| ovf_flag | output | 1 | Sticky wrap flag |

## Verification
The assertions assume that `cnt_low_i` and the bus inputs are stable around each rising edge. The reload property also assumes that no duty-byte write arrives in the same cycle as a reload. The bench therefore drives every input on the falling edge. The counter mostly advances by one and sometimes holds, so wraps are always seen as all ones followed by zero. The reload property also excludes duty-byte writes in a wrap cycle, so random duty writes that land on a wrap do not break it. A reference model in the bench covers those collisions instead. Random length changes can make the masked count jump, and the model follows the same masked-change rule for them.

// File: rtl/arpwm_pkg.sv
package arpwm_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned DUTY_W = 2 * BYTE_W;

  localparam logic [1:0] A_MODE = 2'd0;
  localparam logic [1:0] A_DLO  = 2'd1;
  localparam logic [1:0] A_DHI  = 2'd2;
  localparam logic [1:0] A_CFG  = 2'd3;

  localparam int unsigned MODE_MFE  = 0;
  localparam int unsigned MODE_PWM  = 1;
  localparam int unsigned MODE_CEN  = 2;
  localparam int unsigned FLAG_BIT  = 7;
  localparam int unsigned CFG_RSEL  = 6;

  typedef struct packed {
    logic       mfe;
    logic       pwm;
    logic       cen;
    logic [1:0] lensel;
    logic       rsel;
  } ctrl_t;

  function automatic int unsigned width_of(input logic [1:0] sel,
                                           input int unsigned min_n,
                                           input int unsigned max_n);
    int unsigned n;
    n = min_n + int'(sel);
    if (n > max_n) n = max_n;
    return n;
  endfunction
endpackage

// File: rtl/arpwm_regs.sv
module arpwm_regs
  import arpwm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [1:0]        rd_addr,
  output logic [BYTE_W-1:0] rd_data,
  input  logic              reload,
  input  logic              hw_match,
  input  logic              hw_wrap,
  output ctrl_t             ctrl,
  output logic [DUTY_W-1:0] cmp_q,
  output logic [DUTY_W-1:0] arld_q,
  output logic              match_flag,
  output logic              ovf_flag
);
  logic clr_match, clr_ovf;

  assign clr_match = wr_en && (wr_addr == A_MODE) && !wr_data[FLAG_BIT];
  assign clr_ovf   = wr_en && (wr_addr == A_CFG)  && !wr_data[FLAG_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl   <= '0;
      cmp_q  <= '0;
      arld_q <= '0;
    end else begin
      if (reload) cmp_q <= arld_q;
      if (wr_en) begin
        case (wr_addr)
          A_MODE: begin
            ctrl.mfe <= wr_data[MODE_MFE];
            ctrl.pwm <= wr_data[MODE_PWM];
            ctrl.cen <= wr_data[MODE_CEN];
          end
          A_DLO: begin
            if (ctrl.rsel) arld_q[BYTE_W-1:0] <= wr_data;
            else           cmp_q[BYTE_W-1:0]  <= wr_data;
            ctrl.cen <= 1'b0;
          end
          A_DHI: begin
            if (ctrl.rsel) arld_q[DUTY_W-1:BYTE_W] <= wr_data;
            else           cmp_q[DUTY_W-1:BYTE_W]  <= wr_data;
            ctrl.cen <= 1'b1;
          end
          default: begin
            ctrl.lensel <= wr_data[1:0];
            ctrl.rsel   <= wr_data[CFG_RSEL];
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      match_flag <= 1'b0;
      ovf_flag   <= 1'b0;
    end else begin
      if (hw_match)       match_flag <= 1'b1;
      else if (clr_match) match_flag <= 1'b0;
      if (hw_wrap)        ovf_flag   <= 1'b1;
      else if (clr_ovf)   ovf_flag   <= 1'b0;
    end
  end

  always_comb begin
    case (rd_addr)
      A_MODE:  rd_data = {match_flag, 4'b0, ctrl.cen, ctrl.pwm, ctrl.mfe};
      A_DLO:   rd_data = ctrl.rsel ? arld_q[BYTE_W-1:0] : cmp_q[BYTE_W-1:0];
      A_DHI:   rd_data = ctrl.rsel ? arld_q[DUTY_W-1:BYTE_W] : cmp_q[DUTY_W-1:BYTE_W];
      default: rd_data = {ovf_flag, ctrl.rsel, 4'b0, ctrl.lensel};
    endcase
  end
endmodule

// File: rtl/arpwm_tbase.sv
module arpwm_tbase
  import arpwm_pkg::*;
#(
  parameter int unsigned MIN_N = 9,
  parameter int unsigned MAX_N = 11
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [MAX_N-1:0] cnt_i,
  input  logic [1:0]       lensel,
  output logic [MAX_N-1:0] cnt_masked,
  output logic             step_evt,
  output logic             wrap_evt
);
  logic [MAX_N-1:0] prev_q, mask, old_masked;
  int unsigned      n_cur;

  assign n_cur = width_of(lensel, MIN_N, MAX_N);

  for (genvar b = 0; b < MAX_N; b++) begin : g_mask
    assign mask[b] = (n_cur > b);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= cnt_i;
  end

  assign cnt_masked = cnt_i & mask;
  assign old_masked = prev_q & mask;
  assign step_evt   = (cnt_masked != old_masked);
  assign wrap_evt   = step_evt && (old_masked == mask) && (cnt_masked == '0);
endmodule

// File: rtl/arpwm_cmp_out.sv
module arpwm_cmp_out
  import arpwm_pkg::*;
#(
  parameter int unsigned MAX_N = 11
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              step_evt,
  input  logic              wrap_evt,
  input  logic [MAX_N-1:0]  cnt_masked,
  input  logic [DUTY_W-1:0] cmp_q,
  input  logic [DUTY_W-1:0] arld_q,
  output logic              match_evt,
  output logic              reload,
  output logic              pwm_out
);
  localparam int unsigned PAD = DUTY_W - MAX_N;

  logic [DUTY_W-1:0] cmp_eff;

  assign reload    = active && wrap_evt;
  assign cmp_eff   = reload ? arld_q : cmp_q;
  assign match_evt = active && step_evt && (cmp_eff == {{PAD{1'b0}}, cnt_masked});

  always_ff @(posedge clk) begin
    if (!rst_n)         pwm_out <= 1'b0;
    else if (!active)   pwm_out <= 1'b0;
    else if (match_evt) pwm_out <= 1'b1;
    else if (wrap_evt)  pwm_out <= 1'b0;
  end
endmodule

// File: rtl/arpwm_channel.sv
module arpwm_channel
  import arpwm_pkg::*;
#(
  parameter int unsigned MIN_N = 9,
  parameter int unsigned MAX_N = 11
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [MAX_N-1:0] cnt_low_i,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [7:0]       wr_data,
  input  logic [1:0]       rd_addr,
  output logic [7:0]       rd_data,
  output logic             pwm_out,
  output logic             match_flag,
  output logic             ovf_flag
);
  ctrl_t             ctrl;
  logic [DUTY_W-1:0] cmp_q, arld_q;
  logic [MAX_N-1:0]  cnt_masked;
  logic              step_evt, wrap_evt, match_evt, reload, active, hw_match;

  assign active   = ctrl.cen && ctrl.pwm;
  assign hw_match = match_evt && ctrl.mfe;

  arpwm_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .reload(reload), .hw_match(hw_match),
    .hw_wrap(wrap_evt), .ctrl(ctrl), .cmp_q(cmp_q), .arld_q(arld_q),
    .match_flag(match_flag), .ovf_flag(ovf_flag)
  );

  arpwm_tbase #(.MIN_N(MIN_N), .MAX_N(MAX_N)) u_tbase (
    .clk(clk), .rst_n(rst_n), .cnt_i(cnt_low_i), .lensel(ctrl.lensel),
    .cnt_masked(cnt_masked), .step_evt(step_evt), .wrap_evt(wrap_evt)
  );

  arpwm_cmp_out #(.MAX_N(MAX_N)) u_cmp (
    .clk(clk), .rst_n(rst_n), .active(active), .step_evt(step_evt),
    .wrap_evt(wrap_evt), .cnt_masked(cnt_masked), .cmp_q(cmp_q), .arld_q(arld_q),
    .match_evt(match_evt), .reload(reload), .pwm_out(pwm_out)
  );
endmodule

// File: rtl/arpwm_channel_chk.sv
module arpwm_channel_chk #(
  parameter int unsigned DW = 16
)(
  input logic          clk,
  input logic          rst_n,
  input logic          active,
  input logic          match_evt,
  input logic          wrap_evt,
  input logic          reload,
  input logic          hw_match,
  input logic          pwm_out,
  input logic [DW-1:0] cmp_q,
  input logic [DW-1:0] arld_q,
  input logic          match_flag,
  input logic          ovf_flag,
  input logic          wr_en,
  input logic [1:0]    wr_addr,
  input logic          wr_d7
);
  logic duty_wr, ovf_clr;
  assign duty_wr = wr_en && (wr_addr == 2'd1 || wr_addr == 2'd2);
  assign ovf_clr = wr_en && (wr_addr == 2'd3) && !wr_d7;

  a_r1_match_high: assert property (@(posedge clk) disable iff (!rst_n)
    (active && match_evt) |=> pwm_out);

  a_r2_wrap_low: assert property (@(posedge clk) disable iff (!rst_n)
    (active && wrap_evt && !match_evt) |=> !pwm_out);

  a_r9_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> !pwm_out);

  a_r3_reload_copy: assert property (@(posedge clk) disable iff (!rst_n)
    (reload && !duty_wr) |=> (cmp_q == $past(arld_q)));

  a_r3_ovf_set: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> ovf_flag);

  a_r10_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !ovf_clr) |=> ovf_flag);

  a_r7_match_flag: assert property (@(posedge clk) disable iff (!rst_n)
    hw_match |=> match_flag);
endmodule

bind arpwm_channel arpwm_channel_chk #(.DW(16)) u_chk (
  .clk(clk), .rst_n(rst_n), .active(active), .match_evt(match_evt),
  .wrap_evt(wrap_evt), .reload(reload), .hw_match(hw_match), .pwm_out(pwm_out),
  .cmp_q(cmp_q), .arld_q(arld_q), .match_flag(match_flag), .ovf_flag(ovf_flag),
  .wr_en(wr_en), .wr_addr(wr_addr), .wr_d7(wr_data[7])
);

// File: tb/arpwm_channel_tb_top.sv
module arpwm_channel_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [10:0] cnt_low_i = '0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [1:0]  rd_addr = '0;
  logic [7:0]  rd_data;
  logic        pwm_out, match_flag, ovf_flag;

  int nchk = 0, nerr = 0;

  // reference model state
  bit        m_mfe, m_pwm, m_cen, m_rs, m_mf, m_of, m_out;
  bit [1:0]  m_ls;
  bit [15:0] m_cmp, m_arld;
  bit [10:0] m_prev, cnt;
  bit        cnt_inc = 1'b1;

  always #4 clk = ~clk;

  arpwm_channel dut_i (
    .clk(clk), .rst_n(rst_n), .cnt_low_i(cnt_low_i), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .pwm_out(pwm_out), .match_flag(match_flag), .ovf_flag(ovf_flag)
  );

  function automatic bit [10:0] fmask(input bit [1:0] ls);
    int n;
    n = 9 + int'(ls);
    if (n > 11) n = 11;
    return 11'((32'd1 << n) - 1);
  endfunction

  function automatic int periodof(input bit [1:0] ls);
    return int'(fmask(ls)) + 1;
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input bit we, input bit [1:0] a, input bit [7:0] d);
    bit [10:0] mk, lc, lp;
    bit stp, wrp, act, mt;
    bit [15:0] ce;
    @(negedge clk);
    cnt_low_i = cnt; wr_en = we; wr_addr = a; wr_data = d;
    @(posedge clk);
    mk = fmask(m_ls); lc = cnt & mk; lp = m_prev & mk;
    stp = (lc != lp); wrp = stp && (lp == mk) && (lc == 0);
    act = m_cen && m_pwm;
    ce = (act && wrp) ? m_arld : m_cmp;
    mt = act && stp && (ce == {5'b0, lc});
    if (!act) m_out = 0; else if (mt) m_out = 1; else if (wrp) m_out = 0;
    if (mt && m_mfe) m_mf = 1; else if (we && a == 2'd0 && !d[7]) m_mf = 0;
    if (wrp) m_of = 1; else if (we && a == 2'd3 && !d[7]) m_of = 0;
    if (act && wrp) m_cmp = m_arld;
    if (we) begin
      case (a)
        2'd0: begin m_mfe = d[0]; m_pwm = d[1]; m_cen = d[2]; end
        2'd1: begin if (m_rs) m_arld[7:0] = d; else m_cmp[7:0] = d; m_cen = 0; end
        2'd2: begin if (m_rs) m_arld[15:8] = d; else m_cmp[15:8] = d; m_cen = 1; end
        default: begin m_ls = d[1:0]; m_rs = d[6]; end
      endcase
    end
    m_prev = cnt;
    #1;
    wr_en = 1'b0;
    chk(pwm_out, m_out, "R1 R2 R9 pwm_out");
    chk(match_flag, m_mf, "R7 R10 match_flag");
    chk(ovf_flag, m_of, "R3 R10 ovf_flag");
    cnt = cnt + 11'(cnt_inc);
  endtask

  task automatic rd(input bit [1:0] a, output bit [7:0] v);
    rd_addr = a; #1; v = rd_data;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick(0, 0, 0);
  endtask

  task automatic align(input bit [1:0] ls);
    while ((cnt & fmask(ls)) != 0) tick(0, 0, 0);
  endtask

  task automatic measure(input int n, output int highs, output int falls);
    bit last;
    highs = 0; falls = 0; last = pwm_out;
    for (int i = 0; i < n; i++) begin
      tick(0, 0, 0);
      if (pwm_out) highs++;
      if (last && !pwm_out) falls++;
      last = pwm_out;
    end
  endtask

  task automatic set_duty(input bit [15:0] v);
    tick(1, 2'd1, v[7:0]);
    tick(1, 2'd2, v[15:8]);
  endtask

  initial begin
    bit [7:0] v;
    int h, f;
    process::self().srandom(32'd1234);
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    // R11 reset state
    for (int a = 0; a < 4; a++) begin rd(2'(a), v); chk(v, 0, "R11 reset readback"); end
    chk(pwm_out, 0, "R11 reset pwm_out");

    // R5 / R8: auto-reload access through the select bit
    tick(1, 2'd3, 8'h40);
    tick(1, 2'd1, 8'd100);
    rd(2'd0, v); chk(v[2], 0, "R8 low write clears enable");
    tick(1, 2'd2, 8'd0);
    rd(2'd0, v); chk(v[2], 1, "R8 high write sets enable");
    rd(2'd1, v); chk(v, 100, "R5 select=1 reads auto-reload");
    tick(1, 2'd0, 8'h07);
    tick(1, 2'd3, 8'h00);
    rd(2'd1, v); chk(v, 0, "R5 select=0 reads compare");
    idle(600);
    rd(2'd1, v); chk(v, 100, "R3 compare reloaded at wrap");

    // R9 duty at 9 bits
    align(0); measure(512, h, f);
    chk(h, 412, "R9 duty 9-bit compare 100"); chk(f, 1, "R2 one fall per period");

    // R4 lengths
    tick(1, 2'd3, 8'h01); idle(1100); align(1); measure(2048, h, f);
    chk(f, 2, "R4 10-bit period 1024"); chk(h, 2 * (1024 - 100), "R4 R9 10-bit duty");
    tick(1, 2'd3, 8'h02); idle(2100); align(2); measure(2048, h, f);
    chk(f, 1, "R4 11-bit period 2048"); chk(h, 2048 - 100, "R4 11-bit duty");
    tick(1, 2'd3, 8'h03); idle(2100); align(3); measure(2048, h, f);
    chk(h, 2048 - 100, "R4 code 11 behaves as 11 bits");

    // R6 out-of-range duty never matches at 9 bits, valid at 10
    tick(1, 2'd3, 8'h40); set_duty(16'd600); tick(1, 2'd0, 8'h07);
    idle(1100); align(0); measure(512, h, f);
    chk(h, 0, "R6 duty 600 at 9 bits stays low");
    tick(1, 2'd3, 8'h41); idle(1100); align(1); measure(1024, h, f);
    chk(h, 1024 - 600, "R6 right-justified 600 at 10 bits");

    // R2 compare 0 gives full duty
    tick(1, 2'd3, 8'h40); set_duty(16'd0); idle(1100); align(0); measure(512, h, f);
    chk(h, 512, "R2 compare 0 full duty");

    // R9 inactive: low output, no reload
    tick(1, 2'd1, 8'd50);
    idle(1100); align(0); measure(512, h, f);
    chk(h, 0, "R9 enable clear gives 0 duty");
    tick(1, 2'd3, 8'h00); rd(2'd1, v); chk(v, 0, "R9 no reload while inactive");
    tick(1, 2'd0, 8'h05); idle(1100);
    rd(2'd1, v); chk(v, 0, "R9 pwm mode off blocks reload");

    // R7 match flag enable
    tick(1, 2'd3, 8'h40); set_duty(16'd200);
    tick(1, 2'd0, 8'h06); idle(1100);
    chk(match_flag, 0, "R7 no flag with enable off");
    tick(1, 2'd0, 8'h07); idle(600);
    chk(match_flag, 1, "R7 flag set on match");

    // R10 write 1 keeps, write 0 clears, hardware set wins
    tick(1, 2'd0, 8'h87); chk(match_flag, 1, "R10 write 1 keeps flag");
    tick(1, 2'd0, 8'h07); chk(match_flag, 0, "R10 write 0 clears flag");
    while ((cnt & 11'h1FF) != 11'd200) tick(0, 0, 0);
    tick(1, 2'd0, 8'h07); chk(match_flag, 1, "R10 hardware set beats clear");

    // R12 hold on the match value
    while ((cnt & 11'h1FF) != 11'd200) tick(0, 0, 0);
    cnt_inc = 0;
    tick(0, 0, 0);
    tick(1, 2'd0, 8'h07);
    idle(20);
    chk(match_flag, 0, "R12 held count gives no new match");
    chk(pwm_out, 1, "R12 output holds while count holds");
    cnt_inc = 1;

    // constrained random phase
    for (int i = 0; i < 20000; i++) begin
      bit [1:0] a;
      bit [7:0] d;
      cnt_inc = ($urandom_range(0, 7) != 0);
      a = 2'($urandom_range(0, 3));
      d = 8'($urandom);
      if (a == 2'd3) d[1:0] = (($urandom_range(0, 15) == 0) ? d[1:0] : m_ls);
      if (a == 2'd2) d = 8'($urandom_range(0, 8));
      if ($urandom_range(0, 15) == 0) tick(1, a, d); else tick(0, 0, 0);
    end

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    nerr++;
    nchk++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule